// File: doc/BRIEF.md
# Supply-Compensated Hysteresis Relay

The block is a two-level hysteresis comparator for a sliding-mode inverter controller. On each sample strobe it compares a signed tracking-error word against a symmetric threshold and drives the inverter leg to the positive or the negative level. The threshold is not fixed. When the DC-link supply moves away from its nominal value, the switching rate of a fixed-band relay drifts with it. To hold the peak switching rate near its design point, the block recomputes the band on every sample from the measured supply.

The new band is the programmed nominal band plus a correction. The correction is the supply deviation multiplied by a signed fixed-point sensitivity coefficient that was worked out offline. The result is rounded, saturated to the band width, and then held between a programmable floor and a programmable ceiling. This keeps the threshold away from zero and stops it from growing without limit. A band computed from one sample is first used by the comparison of the following sample, so a threshold never changes part-way through a decision.

Top module: `adapt_band_relay`

## Requirements
- R1: While reset is asserted, and after it is released, the relay output reads 0 (the negative level) and the band output equals the parameter BAND_RST.
- R2: On a strobed sample where the signed error is strictly greater than the current band, the relay output becomes 1 (the positive level) one clock later.
- R3: On a strobed sample where the signed error is strictly less than the negated current band, the relay output becomes 0 one clock later.
- R4: On a strobed sample where the error lies from minus band to plus band, with both limits included, the relay output keeps its value.
- R5: On each strobed sample the band is updated to nominal band + round(dev × sens / 2^FRAC). Here dev is the supply word minus the nominal supply, and sens is a two's-complement coefficient with FRAC fraction bits. Rounding adds half an LSB and then floors, so exact halves round toward plus infinity.
- R6: Before use, that sum is saturated to the range 0 to 2^BW−1 and then limited to the range from the floor register to the ceiling register. The floor is never above the ceiling.
- R7: The comparison made on a strobed sample uses the band computed on the previous strobed sample. The band computed from the current supply word applies from the next strobe onward.
- R8: Without a strobe, both outputs hold their values, whatever the error and supply inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; error and supply are taken when high |
| err_in | input | EW | Signed tracking error |
| vdc_in | input | SW | Measured supply word, unsigned |
| vdc_nom | input | SW | Nominal supply word, unsigned |
| band_nom | input | BW | Band at nominal supply, unsigned |
| sens_q | input | KW | Signed sensitivity, FRAC fraction bits |
| band_min | input | BW | Band floor |
| band_max | input | BW | Band ceiling |
| relay_out | output | 1 | Relay level: 1 positive, 0 negative |
| band_out | output | BW | Band in force for the next comparison |

## Verification
The assertions assume that the configuration inputs are steady when a strobe arrives and that the floor never exceeds the ceiling. Only under that assumption is the clamp property meaningful. The stimulus changes the configuration only between strobes, with the strobe low, and always keeps the floor at or below the ceiling, even when it drops the floor to zero and opens the ceiling to the full range. The supply is ramped across and beyond both clamp points, and it includes odd deviations, so that exact half-LSB ties occur.

// File: rtl/ahb_pkg.sv
package ahb_pkg;
  typedef enum logic {
    RLY_NEG = 1'b0,
    RLY_POS = 1'b1
  } rly_e;
endpackage

// File: rtl/hb_corr.sv
// Supply deviation times sensitivity, rounded back to integer band units.
module hb_corr #(
  parameter int SW   = 12,
  parameter int KW   = 16,
  parameter int FRAC = 8,
  localparam int PW  = SW + KW + 1
) (
  input  logic [SW-1:0]        vdc,
  input  logic [SW-1:0]        vdc_ref,
  input  logic signed [KW-1:0] sens,
  output logic signed [PW-1:0] corr
);
  logic signed [SW:0]   dev;
  logic signed [PW-1:0] prod;

  assign dev  = $signed({1'b0, vdc}) - $signed({1'b0, vdc_ref});
  assign prod = $signed({{KW{dev[SW]}}, dev} * {{(SW+1){sens[KW-1]}}, sens});

  generate
    if (FRAC > 0) begin : g_round
      localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);
      logic signed [PW-1:0] biased;
      assign biased = prod + $signed(HALF);
      assign corr   = biased >>> FRAC;
    end else begin : g_noround
      assign corr = prod;
    end
  endgenerate
endmodule

// File: rtl/hb_limit.sv
// Nominal band plus correction, saturated to BW bits, then held between floor and ceiling.
module hb_limit #(
  parameter int BW = 15,
  parameter int PW = 29
) (
  input  logic [BW-1:0]        nom,
  input  logic signed [PW-1:0] corr,
  input  logic [BW-1:0]        lo,
  input  logic [BW-1:0]        hi,
  output logic [BW-1:0]        band_nx
);
  localparam logic signed [PW:0] TOP = $signed({{(PW+1-BW){1'b0}}, {BW{1'b1}}});

  logic signed [PW:0] sum;
  logic [BW-1:0]      sat;

  assign sum = $signed({{(PW+1-BW){1'b0}}, nom}) + $signed({corr[PW-1], corr});

  always_comb begin
    if (sum < 0)        sat = '0;
    else if (sum > TOP) sat = '1;
    else                sat = sum[BW-1:0];

    if (sat > hi)      band_nx = hi;
    else if (sat < lo) band_nx = lo;
    else               band_nx = sat;
  end
endmodule

// File: rtl/hb_relay.sv
// Two-level relay with symmetric threshold, advanced only on the strobe.
module hb_relay
  import ahb_pkg::*;
#(
  parameter int EW = 16,
  parameter int BW = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [EW-1:0] err,
  input  logic [BW-1:0]       band,
  output rly_e                state
);
  logic signed [EW:0] e_x, b_x;
  rly_e               st_d;

  assign e_x = {err[EW-1], err};
  assign b_x = $signed({{(EW+1-BW){1'b0}}, band});

  always_comb begin
    st_d = state;
    if (en) begin
      if (e_x > b_x)       st_d = RLY_POS;
      else if (e_x < -b_x) st_d = RLY_NEG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RLY_NEG;
    else        state <= st_d;
  end
endmodule

// File: rtl/adapt_band_relay.sv
module adapt_band_relay
  import ahb_pkg::*;
#(
  parameter int EW   = 16,
  parameter int SW   = 12,
  parameter int BW   = 15,
  parameter int KW   = 16,
  parameter int FRAC = 8,
  parameter logic [BW-1:0] BAND_RST = BW'(1000)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [EW-1:0] err_in,
  input  logic [SW-1:0]        vdc_in,
  input  logic [SW-1:0]        vdc_nom,
  input  logic [BW-1:0]        band_nom,
  input  logic signed [KW-1:0] sens_q,
  input  logic [BW-1:0]        band_min,
  input  logic [BW-1:0]        band_max,
  output logic                 relay_out,
  output logic [BW-1:0]        band_out
);
  localparam int PW = SW + KW + 1;

  logic signed [PW-1:0] corr;
  logic [BW-1:0]        band_nx, band_d, band_q;
  rly_e                 rly_st;

  hb_corr #(.SW(SW), .KW(KW), .FRAC(FRAC)) corr_i (
    .vdc(vdc_in), .vdc_ref(vdc_nom), .sens(sens_q), .corr(corr)
  );

  hb_limit #(.BW(BW), .PW(PW)) lim_i (
    .nom(band_nom), .corr(corr), .lo(band_min), .hi(band_max), .band_nx(band_nx)
  );

  hb_relay #(.EW(EW), .BW(BW)) rly_i (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .err(err_in), .band(band_q), .state(rly_st)
  );

  always_comb begin
    band_d = band_q;
    if (smp_vld) band_d = band_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) band_q <= BAND_RST;
    else        band_q <= band_d;
  end

  assign band_out  = band_q;
  assign relay_out = (rly_st == RLY_POS);
endmodule

// File: rtl/adapt_band_relay_chk.sv
module adapt_band_relay_chk #(
  parameter int EW = 16,
  parameter int BW = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_vld,
  input logic signed [EW-1:0] err_in,
  input logic [BW-1:0]        band_min,
  input logic [BW-1:0]        band_max,
  input logic                 relay_out,
  input logic [BW-1:0]        band_out
);
  logic signed [EW:0] e_x, b_x;
  assign e_x = {err_in[EW-1], err_in};
  assign b_x = $signed({{(EW+1-BW){1'b0}}, band_out});

  a_r2_up: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (e_x > b_x) |=> relay_out);

  a_r3_down: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (e_x < -b_x) |=> !relay_out);

  a_r4_inside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (e_x <= b_x) && (e_x >= -b_x) |=> $stable(relay_out));

  a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (band_min <= band_max) |=>
      (band_out >= $past(band_min)) && (band_out <= $past(band_max)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(relay_out) && $stable(band_out));
endmodule

bind adapt_band_relay adapt_band_relay_chk #(.EW(EW), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .err_in(err_in),
  .band_min(band_min), .band_max(band_max),
  .relay_out(relay_out), .band_out(band_out)
);

// File: tb/adapt_band_relay_tb_top.sv
module adapt_band_relay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 16, SW = 12, BW = 15, KW = 16, FRAC = 8;
  localparam int RSTB = 1000;
  localparam int NV = 16;
  localparam int VDCV [NV] = '{1348, 1448, 1549, 1648, 1749, 1848, 1947, 2048,
                               2149, 2248, 2349, 2448, 2549, 2648, 2749, 2848};
  localparam int ERRV [NV] = '{1500, -1500, 800, -800, 0, 1200, -1200, 1000,
                               -1001, 1001, 50, -2000, 2000, -1250, 1299, -1301};

  logic clk = 1'b0;
  logic rst_n;
  logic smp_vld;
  logic signed [EW-1:0] err_in;
  logic [SW-1:0] vdc_in, vdc_nom;
  logic [BW-1:0] band_nom, band_min, band_max;
  logic signed [KW-1:0] sens_q;
  logic relay_out;
  logic [BW-1:0] band_out;

  int n_chk = 0, n_bad = 0;
  int m_band, m_rly;

  always #(CLK_PERIOD/2) clk = ~clk;

  adapt_band_relay #(.EW(EW), .SW(SW), .BW(BW), .KW(KW), .FRAC(FRAC),
                     .BAND_RST(BW'(RSTB))) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .err_in(err_in),
    .vdc_in(vdc_in), .vdc_nom(vdc_nom), .band_nom(band_nom), .sens_q(sens_q),
    .band_min(band_min), .band_max(band_max),
    .relay_out(relay_out), .band_out(band_out)
  );

  function automatic int exp_band(int v);
    int dev, p, c, s;
    dev = v - int'(vdc_nom);
    p   = dev * int'(sens_q);
    c   = (p + (1 << (FRAC - 1))) >>> FRAC;
    s   = int'(band_nom) + c;
    if (s < 0) s = 0;
    if (s > (1 << BW) - 1) s = (1 << BW) - 1;
    if (s > int'(band_max)) s = int'(band_max);
    if (s < int'(band_min)) s = int'(band_min);
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input int e, input int v);
    err_in  = EW'(e);
    vdc_in  = SW'(v);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    if (e > m_band)       m_rly = 1;
    else if (e < -m_band) m_rly = 0;
    m_band = exp_band(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; err_in = '0; vdc_in = 12'd2048;
    vdc_nom = 12'd2048; band_nom = 15'd1000; sens_q = 16'sd128;
    band_min = 15'd700; band_max = 15'd1300;
    m_band = RSTB; m_rly = 0;
    repeat (3) @(negedge clk);
    check("R1 relay in reset", int'(relay_out), 0);
    check("R1 band in reset", int'(band_out), RSTB);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 relay after reset", int'(relay_out), 0);
    check("R1 band after reset", int'(band_out), RSTB);

    // supply ramp table across both clamp points
    for (int i = 0; i < NV; i++) begin
      sample(ERRV[i], VDCV[i]);
      check("R2/R3/R4 relay table", int'(relay_out), m_rly);
      check("R5/R6 band table", int'(band_out), m_band);
    end

    // R5 rounding of exact halves toward plus infinity
    sample(0, 2149);
    check("R5 tie up", int'(band_out), 1051);
    sample(0, 1947);
    check("R5 tie negative", int'(band_out), 950);

    // R7 comparison uses the band from the previous strobe
    sample(-2000, 2048);
    check("R3 set negative", int'(relay_out), 0);
    sample(1100, 2648);
    check("R7 old band used", int'(relay_out), 1);
    check("R7 new band loaded", int'(band_out), 1300);
    sample(-1200, 2048);
    check("R7 hold within new band", int'(relay_out), 1);
    check("R5 band back to nominal", int'(band_out), 1000);
    sample(-1000, 2048);
    check("R4 equal negative band holds", int'(relay_out), 1);
    sample(-1001, 2048);
    check("R3 below negative band", int'(relay_out), 0);
    sample(1000, 2048);
    check("R4 equal band holds", int'(relay_out), 0);
    sample(1001, 2048);
    check("R2 above band", int'(relay_out), 1);

    // R8 no strobe: inputs ignored
    err_in = -16'sd3000; vdc_in = 12'd4000;
    repeat (5) @(negedge clk);
    check("R8 relay held", int'(relay_out), 1);
    check("R8 band held", int'(band_out), 1000);

    // R6 saturation at zero and at full scale
    band_min = 15'd0; band_max = 15'h7FFF;
    @(negedge clk);
    sample(0, 0);
    check("R6 floor saturate", int'(band_out), 0);
    sens_q = 16'sh7FFF;
    @(negedge clk);
    sample(-5, 4095);
    check("R2/R3 zero band compare", int'(relay_out), 0);
    check("R6 top saturate", int'(band_out), 32767);
    check("R6 model agrees", int'(band_out), m_band);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule